// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Register

This block holds the sticky interrupt flags of a CAN-style controller that owns a set of message buffers. Every buffer reports a finished transmit or receive with a one-cycle pulse, and the matching flag bit latches it until software clears it by writing a 1 to that bit. A second register of the same width selects which flags may raise the single interrupt request line.

When the receive FIFO is switched on, the three flags just below the first dedicated buffer flag stop tracking buffers 7, 6 and 5. Bit 7 then reports a frame lost to a full FIFO. Bit 6 becomes an almost-full warning raised by the store that lifts occupancy from 4 to 5. Bit 5 mirrors whether any unread frame is waiting. Any change of the FIFO enable input wipes these three bits, so flags from one meaning never carry over into the other. The FIFO storage and the protocol engine sit outside this block. They supply the event pulses and the current occupancy count.

Top module: `mbif_irq_flags`

## Requirements
- R1: After reset every flag, the interrupt mask and `irq_o` are 0.
- R2: A pulse on `buf_done[i]` for any i from 8 upward sets `flags_o[i]` at the next clock edge, and the bit stays set until software clears it.
- R3: With `fifo_mode` low, `buf_done[7:5]` set `flags_o[7:5]` in the same way, and the FIFO event inputs have no effect on any flag.
- R4: With `fifo_mode` high, `flags_o[7]` sets one clock after `rx_drop_full` is high while `rx_to_mbox` is low. It does not set when `rx_to_mbox` is high, and `buf_done[7:5]` are ignored.
- R5: With `fifo_mode` high, `flags_o[6]` sets one clock after `rx_stored` is high with `fifo_count` equal to 4 and `rx_read` low. `fifo_count` is the occupancy before that cycle's events. A store at any other count, or a store at count 4 with a simultaneous read, does not set it.
- R6: If software clears `flags_o[6]` while `fifo_count` is above 4, further stores leave it clear until a store happens again at count 4.
- R7: With `fifo_mode` high, `flags_o[5]` equals (`fifo_count` != 0) as sampled at the previous clock edge. A software clear has no effect while frames remain.
- R8: In any cycle where `fifo_mode` differs from its value at the previous edge, `flags_o[7:5]` are cleared at the next edge. This clear overrides every set source. Bits 31 to 8 are untouched.
- R9: A write with `reg_wr` high and `reg_sel` = 0 clears each flag whose `reg_wdata` bit is 1 and leaves flags whose bit is 0 unchanged. If a set event and a clear hit the same bit in one cycle, the bit ends up set.
- R10: A write with `reg_wr` high and `reg_sel` = 1 loads the mask. `irq_o` is registered and always equals the OR of (`flags_o` AND mask), so it updates on the same edge as the flags or the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_done | input | NUM_BUF | Per-buffer completion pulses |
| fifo_mode | input | 1 | Receive FIFO enable level |
| rx_stored | input | 1 | A frame was written into the FIFO |
| rx_read | input | 1 | A frame was read from the FIFO |
| rx_drop_full | input | 1 | A frame was lost because the FIFO was full |
| rx_to_mbox | input | 1 | A frame arriving at a full FIFO was taken by a mailbox |
| fifo_count | input | CNT_W | Unread frames in the FIFO before this cycle's events |
| reg_wr | input | 1 | CPU write strobe |
| reg_sel | input | 1 | Write target: 0 flags (write-1-to-clear), 1 mask |
| reg_wdata | input | NUM_BUF | CPU write data |
| flags_o | output | NUM_BUF | Flag vector |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
Two things can collide on one bit in the same cycle: a hardware set and a software write-1-to-clear. The bench drives a completion pulse and a clear of the same bit together and expects the bit to stay set. A second collision is between a change of the FIFO enable and the FIFO-meaning set sources, including the level-following frames-available bit. The bench changes the mode while occupancy is nonzero and expects the low three bits to read zero for one cycle before the level bit returns.

// File: rtl/mbif_pkg.sv
package mbif_pkg;
  typedef enum logic {SEL_FLAGS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
  localparam int OVF_BIT   = 7;
  localparam int WARN_BIT  = 6;
  localparam int AVAIL_BIT = 5;
endpackage

// File: rtl/mbif_fifo_status.sv
module mbif_fifo_status #(
  parameter int CNT_W    = 4,
  parameter int WARN_LVL = 4
) (
  input  logic             rx_stored,
  input  logic             rx_read,
  input  logic             rx_drop_full,
  input  logic             rx_to_mbox,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             ovf_set,
  output logic             warn_set,
  output logic             avail_lvl
);
  localparam logic [CNT_W-1:0] WARN_CNT = CNT_W'(WARN_LVL);

  // A frame counts as lost only if no mailbox took it.
  assign ovf_set   = rx_drop_full & ~rx_to_mbox;
  // The warning fires on the single store that steps occupancy past the
  // threshold; once above it, no store can fire again until the count has
  // come back down to the threshold.
  assign warn_set  = rx_stored & ~rx_read & (fifo_count == WARN_CNT);
  assign avail_lvl = (fifo_count != '0);
endmodule

// File: rtl/mbif_flag_bank.sv
module mbif_flag_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] w1c_vec,
  input  logic [W-1:0] kill_vec,
  input  logic [W-1:0] lvl_en_vec,
  input  logic [W-1:0] lvl_val_vec,
  output logic [W-1:0] flag_d,
  output logic [W-1:0] flag_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      if (kill_vec[i])
        flag_d[i] = 1'b0;
      else if (lvl_en_vec[i])
        flag_d[i] = lvl_val_vec[i];
      else
        flag_d[i] = set_vec[i] | (flag_q[i] & ~w1c_vec[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/mbif_irq_reduce.sv
module mbif_irq_reduce #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] flag_d,
  output logic [W-1:0] mask_q,
  output logic         irq_q
);
  logic [W-1:0] mask_d;

  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(flag_d & mask_d);
    end
  end
endmodule

// File: rtl/mbif_irq_flags.sv
module mbif_irq_flags
  import mbif_pkg::*;
#(
  parameter int NUM_BUF  = 32,
  parameter int CNT_W    = 4,
  parameter int WARN_LVL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic               fifo_mode,
  input  logic               rx_stored,
  input  logic               rx_read,
  input  logic               rx_drop_full,
  input  logic               rx_to_mbox,
  input  logic [CNT_W-1:0]   fifo_count,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [NUM_BUF-1:0] reg_wdata,
  output logic [NUM_BUF-1:0] flags_o,
  output logic               irq_o
);
  logic               mode_q;
  logic               mode_chg;
  logic               ovf_set, warn_set, avail_lvl;
  logic               flag_w1c_en, mask_we;
  logic [NUM_BUF-1:0] set_vec, w1c_vec, kill_vec, lvl_en_vec, lvl_val_vec;
  logic [NUM_BUF-1:0] flag_d, mask_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= fifo_mode;
  end

  assign mode_chg    = fifo_mode ^ mode_q;
  assign flag_w1c_en = reg_wr & (reg_sel_e'(reg_sel) == SEL_FLAGS);
  assign mask_we     = reg_wr & (reg_sel_e'(reg_sel) == SEL_MASK);
  assign w1c_vec     = flag_w1c_en ? reg_wdata : '0;

  mbif_fifo_status #(.CNT_W(CNT_W), .WARN_LVL(WARN_LVL)) u_fifo_st (
    .rx_stored    (rx_stored),
    .rx_read      (rx_read),
    .rx_drop_full (rx_drop_full),
    .rx_to_mbox   (rx_to_mbox),
    .fifo_count   (fifo_count),
    .ovf_set      (ovf_set),
    .warn_set     (warn_set),
    .avail_lvl    (avail_lvl)
  );

  // Route set sources per bit: the three low shared bits pick their meaning
  // from the registered mode; all other bits follow their buffer.
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_route
    if (i == OVF_BIT) begin : g_ovf
      assign set_vec[i]     = mode_q ? ovf_set : buf_done[i];
      assign lvl_en_vec[i]  = 1'b0;
      assign lvl_val_vec[i] = 1'b0;
      assign kill_vec[i]    = mode_chg;
    end else if (i == WARN_BIT) begin : g_warn
      assign set_vec[i]     = mode_q ? warn_set : buf_done[i];
      assign lvl_en_vec[i]  = 1'b0;
      assign lvl_val_vec[i] = 1'b0;
      assign kill_vec[i]    = mode_chg;
    end else if (i == AVAIL_BIT) begin : g_avail
      assign set_vec[i]     = mode_q ? 1'b0 : buf_done[i];
      assign lvl_en_vec[i]  = mode_q;
      assign lvl_val_vec[i] = avail_lvl;
      assign kill_vec[i]    = mode_chg;
    end else begin : g_plain
      assign set_vec[i]     = buf_done[i];
      assign lvl_en_vec[i]  = 1'b0;
      assign lvl_val_vec[i] = 1'b0;
      assign kill_vec[i]    = 1'b0;
    end
  end

  mbif_flag_bank #(.W(NUM_BUF)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .set_vec     (set_vec),
    .w1c_vec     (w1c_vec),
    .kill_vec    (kill_vec),
    .lvl_en_vec  (lvl_en_vec),
    .lvl_val_vec (lvl_val_vec),
    .flag_d      (flag_d),
    .flag_q      (flags_o)
  );

  mbif_irq_reduce #(.W(NUM_BUF)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata),
    .flag_d     (flag_d),
    .mask_q     (mask_q),
    .irq_q      (irq_o)
  );
endmodule

// File: rtl/mbif_checker.sv
module mbif_checker #(
  parameter int NUM_BUF  = 32,
  parameter int CNT_W    = 4,
  parameter int WARN_LVL = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_BUF-1:0] buf_done,
  input logic               fifo_mode,
  input logic               rx_drop_full,
  input logic               rx_to_mbox,
  input logic [CNT_W-1:0]   fifo_count,
  input logic               reg_wr,
  input logic               reg_sel,
  input logic [NUM_BUF-1:0] reg_wdata,
  input logic [NUM_BUF-1:0] flags_o,
  input logic               irq_o,
  input logic               mode_q,
  input logic [NUM_BUF-1:0] mask_q
);
  localparam int TOP = NUM_BUF - 1;

  assert_set_top_R2: assert property (@(posedge clk) disable iff (rst)
    buf_done[TOP] |=> flags_o[TOP]);

  assert_w1c_top_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && reg_wdata[TOP] && !buf_done[TOP]) |=> !flags_o[TOP]);

  assert_keep_top_R9: assert property (@(posedge clk) disable iff (rst)
    (flags_o[TOP] && !(reg_wr && !reg_sel && reg_wdata[TOP])) |=> flags_o[TOP]);

  assert_no_ovf_mbox_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q && fifo_mode && rx_to_mbox && !flags_o[7]) |=> !flags_o[7]);

  assert_warn_stays_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_q && fifo_mode && !flags_o[6] && fifo_count > CNT_W'(WARN_LVL))
      |=> !flags_o[6]);

  assert_avail_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q && fifo_mode && fifo_count != '0) |=> flags_o[5]);

  assert_mode_change_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode != mode_q) |=> (flags_o[7:5] == 3'b000));

  assert_irq_matches_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flags_o & mask_q));
endmodule

bind mbif_irq_flags mbif_checker #(
  .NUM_BUF(NUM_BUF), .CNT_W(CNT_W), .WARN_LVL(WARN_LVL)
) u_chk (
  .clk(clk), .rst(rst), .buf_done(buf_done), .fifo_mode(fifo_mode),
  .rx_drop_full(rx_drop_full), .rx_to_mbox(rx_to_mbox),
  .fifo_count(fifo_count), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .flags_o(flags_o), .irq_o(irq_o),
  .mode_q(mode_q), .mask_q(mask_q)
);

// File: tb/mbif_irq_flags_tb.sv
module mbif_irq_flags_tb;
  localparam int NB = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] buf_done = '0;
  logic          fifo_mode = 1'b0;
  logic          rx_stored = 1'b0, rx_read = 1'b0;
  logic          rx_drop_full = 1'b0, rx_to_mbox = 1'b0;
  logic [CW-1:0] fifo_count = '0;
  logic          reg_wr = 1'b0, reg_sel = 1'b0;
  logic [NB-1:0] reg_wdata = '0;
  logic [NB-1:0] flags_o;
  logic          irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mbif_irq_flags #(.NUM_BUF(NB), .CNT_W(CW), .WARN_LVL(4)) u_dut (
    .clk(clk), .rst(rst), .buf_done(buf_done), .fifo_mode(fifo_mode),
    .rx_stored(rx_stored), .rx_read(rx_read), .rx_drop_full(rx_drop_full),
    .rx_to_mbox(rx_to_mbox), .fifo_count(fifo_count), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock edge, then drop all pulse inputs.
  task automatic step();
    @(negedge clk);
    buf_done = '0; rx_stored = 0; rx_read = 0; rx_drop_full = 0;
    rx_to_mbox = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
  endtask

  task automatic wr(input logic sel, input logic [NB-1:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [NB-1:0] pat;
    pat = 32'hA5C3_5A00;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 flags", flags_o, '0);
    chk("R1 irq", {31'b0, irq_o}, '0);

    // R2: every dedicated buffer bit sets and is then cleared.
    for (int i = 8; i < NB; i++) begin
      buf_done = NB'(1) << i; step();
      chk("R2 set", flags_o, NB'(1) << i);
      step();
      chk("R2 sticky", flags_o, NB'(1) << i);
      wr(0, NB'(1) << i); step();
      chk("R9 clear", flags_o, '0);
    end

    // R3: normal mode low bits and ignored FIFO events.
    buf_done = 32'h0000_00E0; step();
    chk("R3 low bits", flags_o, 32'h0000_00E0);
    wr(0, 32'h0000_00E0); step();
    fifo_count = 4; rx_stored = 1; rx_drop_full = 1; step();
    chk("R3 fifo ignored", flags_o, '0);
    fifo_count = 0;

    // R9: writing 0 keeps, set beats clear.
    buf_done[20] = 1; step();
    wr(0, 32'h0); step();
    chk("R9 write zero", flags_o, 32'h0010_0000);
    wr(0, 32'h0010_0000); buf_done[20] = 1; step();
    chk("R9 set wins", flags_o, 32'h0010_0000);
    wr(0, '1); step();

    // R10: mask sweep over a flag pattern.
    buf_done = pat; step();
    chk("R10 pattern", flags_o, pat);
    chk("R10 no mask", {31'b0, irq_o}, '0);
    for (int i = 8; i < NB; i++) begin
      wr(1, NB'(1) << i); step();
      chk("R10 irq", {31'b0, irq_o}, {31'b0, pat[i]});
    end
    wr(1, '0); step();
    wr(0, '1); step();

    // R8: entering FIFO mode clears low bits, keeps high ones.
    buf_done = 32'h8000_00E0; step();
    fifo_mode = 1; fifo_count = 3; step();
    chk("R8 enter clear", flags_o, 32'h8000_0000);
    step();
    chk("R7 after change", {31'b0, flags_o[5]}, 32'h1);
    fifo_count = 0; step();

    // R4: overflow versus mailbox capture, buffers 7..5 ignored.
    rx_drop_full = 1; rx_to_mbox = 1; step();
    chk("R4 mbox", {31'b0, flags_o[7]}, '0);
    buf_done = 32'h0000_00E0; step();
    chk("R4 buf ignored", {29'b0, flags_o[7:5]}, '0);
    rx_drop_full = 1; step();
    chk("R4 overflow", {31'b0, flags_o[7]}, 32'h1);

    // R7: frames available follows count.
    fifo_count = 2; step();
    chk("R7 avail", {31'b0, flags_o[5]}, 32'h1);
    wr(0, 32'h20); step();
    chk("R7 w1c ignored", {31'b0, flags_o[5]}, 32'h1);
    fifo_count = 0; step();
    chk("R7 empty", {31'b0, flags_o[5]}, '0);

    // R5: warning sweep over store counts.
    for (int c = 0; c < 8; c++) begin
      fifo_count = CW'(c); rx_stored = 1; step();
      chk("R5 warn sweep", {31'b0, flags_o[6]}, {31'b0, c == 4});
      wr(0, 32'h40); step();
    end
    fifo_count = 4; rx_stored = 1; rx_read = 1; step();
    chk("R5 store with read", {31'b0, flags_o[6]}, '0);

    // R6: clear above threshold stays clear.
    fifo_count = 4; rx_stored = 1; step();
    chk("R6 set", {31'b0, flags_o[6]}, 32'h1);
    fifo_count = 5; wr(0, 32'h40); step();
    chk("R6 cleared", {31'b0, flags_o[6]}, '0);
    rx_stored = 1; step();
    fifo_count = 6; rx_stored = 1; step();
    chk("R6 no rearm", {31'b0, flags_o[6]}, '0);
    fifo_count = 4; rx_stored = 1; step();
    chk("R6 rearm", {31'b0, flags_o[6]}, 32'h1);

    // R8: leaving FIFO mode clears low bits again; set collides with clear.
    fifo_mode = 0; buf_done = 32'h0000_00E0; step();
    chk("R8 leave clear", flags_o, 32'h8000_0000);
    fifo_count = 0;

    // R10: full mask then full clear.
    wr(1, '1); step();
    chk("R10 all mask", {31'b0, irq_o}, 32'h1);
    wr(0, '1); step();
    chk("R10 cleared", {31'b0, irq_o}, '0);
    chk("R9 all clear", flags_o, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule